// File: doc/BRIEF.md
# Audio Serial Port Status Unit

This block holds the status logic of one audio serial port. It turns the current fill count of the port's sample FIFO into a three-bit level code. The boundaries of the four quarter bands sit on different sides depending on whether the port transmits or receives. It also watches the incoming frame-sync line against a free-running frame-length counter. In slave mode it records a sync that arrives early and a sync that fails to arrive on time, each in its own sticky error flag.

The results are gathered into a 32-bit read-only status word. Separate clear strobes, taken from a companion clear register, reset the error flags. Per-flag enable bits gate them onto a single registered interrupt line. Bit 3 of the word reports that no frame-sync rising edge has been seen since reset. Sync error checking starts only once that bit has dropped.

Top module: `aud_stat_unit`

## Requirements
- R1: After reset the status word reads 0x0000_0008 and the interrupt output is 0.
- R2: In transmit mode (tx_mode=1), with a FIFO of DEPTH entries holding c samples, status bits 18:16 read 000 when c=0, 101 when c=DEPTH, and otherwise 001 for c<=DEPTH/4, 010 for c<=DEPTH/2, 011 for c<=3*DEPTH/4, and 100 above that. The code follows a count change one clock later.
- R3: In receive mode (tx_mode=0), bits 18:16 read 000 when c=0 and 101 when c=DEPTH. Otherwise they read 001 for c<DEPTH/4, 010 for c<DEPTH/2, 011 for c<3*DEPTH/4, and 100 at or above that. The code follows a count change one clock later.
- R4: Bits 31:19, 15:7, 4 and 2:0 of the status word always read 0.
- R5: Bit 3 (unlocked) is 1 from reset until the clock after the first rising edge of fsync in any mode, and 0 from then on. While bit 3 is 1 no sync error flag sets.
- R6: The frame counter counts 0 to FRAME_LEN-1 and wraps. A rising fsync edge seen while the counter is not at FRAME_LEN-1 sets the early flag (bit 5) one clock later and restarts the counter at 0, so the next on-time edge is FRAME_LEN clocks after the early one.
- R7: If no rising fsync edge is seen while the counter is at FRAME_LEN-1, the late flag (bit 6) sets one clock later and the counter wraps to 0 as usual.
- R8: A rising fsync edge that comes exactly FRAME_LEN clocks after the previous accepted edge sets neither flag.
- R9: Neither error flag sets unless slave_mode=1 and ac97_mode=0.
- R10: Each error flag stays set until its own clear strobe (clr_late, clr_early) is 1 for a clock. A clear in a clock where the flag's set condition also holds leaves the flag set.
- R11: irq is 1 exactly when, one clock earlier, (bit 6 AND irq_en_late) OR (bit 5 AND irq_en_early) held.
- R12: Level codes 110 and 111 never appear in bits 18:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; the frame counter advances once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 selects transmit band rules, 0 receive |
| slave_mode | input | 1 | 1 when the frame sync comes from outside |
| ac97_mode | input | 1 | 1 selects the codec-link mode, which disables sync checking |
| fifo_count | input | $clog2(FIFO_DEPTH+1) | Current number of samples in the FIFO |
| fsync | input | 1 | Frame-sync line, already in the clk domain |
| clr_early | input | 1 | Clear strobe for the early-sync flag |
| clr_late | input | 1 | Clear strobe for the late-sync flag |
| irq_en_early | input | 1 | Interrupt enable for the early-sync flag |
| irq_en_late | input | 1 | Interrupt enable for the late-sync flag |
| status_word | output | 32 | Read-only status word |
| irq | output | 1 | Registered interrupt request |

## Verification
The level code, the error flags and the unlocked bit are each one register away from their inputs. Every such result is therefore due at the first rising clock after the stimulus. The bench drives on falling edges and samples on the next falling edge. The interrupt adds a second register, so its checks sample one falling edge after the flag is seen, and they also confirm that irq is still low at the flag's own sample point. For sync timing, fsync edges are placed a counted number of falling edges after the locking edge. The early, on-time and late cases therefore land on known counter values, and each late check confirms that the flag is still clear one cycle before it is due.

// File: rtl/aud_stat_pkg.sv
package aud_stat_pkg;

  typedef enum logic [2:0] {
    LVL_EMPTY = 3'd0,
    LVL_B1    = 3'd1,
    LVL_B2    = 3'd2,
    LVL_B3    = 3'd3,
    LVL_B4    = 3'd4,
    LVL_FULL  = 3'd5
  } lvl_code_e;

  localparam int unsigned SW_LVL_LO   = 16;
  localparam int unsigned SW_LATE     = 6;
  localparam int unsigned SW_EARLY    = 5;
  localparam int unsigned SW_UNLOCKED = 3;

  // Band rule: scale the count by 4 and compare against multiples of depth.
  // Transmit bands include their upper bound, receive bands their lower bound.
  function automatic lvl_code_e lvl_encode(input int unsigned cnt,
                                           input int unsigned depth,
                                           input logic tx);
    int unsigned c4;
    c4 = cnt * 4;
    if (cnt == 0)            return LVL_EMPTY;
    if (cnt >= depth)        return LVL_FULL;
    if (tx) begin
      if (c4 <= depth)       return LVL_B1;
      if (c4 <= 2 * depth)   return LVL_B2;
      if (c4 <= 3 * depth)   return LVL_B3;
      return LVL_B4;
    end
    if (c4 < depth)          return LVL_B1;
    if (c4 < 2 * depth)      return LVL_B2;
    if (c4 < 3 * depth)      return LVL_B3;
    return LVL_B4;
  endfunction

endpackage

// File: rtl/aud_fifo_level.sv
module aud_fifo_level
  import aud_stat_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_mode,
  input  logic [CNT_W-1:0] fifo_count,
  output logic [2:0]       level_q
);

  lvl_code_e lvl_next_w;

  always_comb lvl_next_w = lvl_encode(32'(fifo_count), FIFO_DEPTH, tx_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= LVL_EMPTY;
    else        level_q <= lvl_next_w;
  end

  // R12
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= 3'd5);

  // R2
  lvl_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |=> (level_q == 3'd0));

  // R3
  lvl_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_count) == FIFO_DEPTH) |=> (level_q == 3'd5));

endmodule

// File: rtl/aud_fsync_mon.sv
module aud_fsync_mon #(
  parameter int unsigned FRAME_LEN = 8,
  localparam int unsigned FC_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1,
  localparam logic [FC_W-1:0] LAST = FC_W'(FRAME_LEN - 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_mode,
  input  logic ac97_mode,
  input  logic fsync,
  input  logic clr_early,
  input  logic clr_late,
  output logic early_q,
  output logic late_q,
  output logic unlocked_q
);

  logic            fs_q;
  logic [FC_W-1:0] cnt_q;

  // Named internal events, shared by the flag logic and the assertions
  logic fs_edge_w;
  logic at_wrap_w;
  logic chk_en_w;
  logic early_set_w;
  logic late_set_w;

  always_comb begin
    fs_edge_w   = fsync & ~fs_q;
    at_wrap_w   = (cnt_q == LAST);
    chk_en_w    = slave_mode & ~ac97_mode & ~unlocked_q;
    early_set_w = chk_en_w & fs_edge_w & ~at_wrap_w;
    late_set_w  = chk_en_w & ~fs_edge_w & at_wrap_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q       <= 1'b0;
      cnt_q      <= '0;
      unlocked_q <= 1'b1;
      early_q    <= 1'b0;
      late_q     <= 1'b0;
    end else begin
      fs_q <= fsync;
      if (fs_edge_w || at_wrap_w) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
      if (fs_edge_w) unlocked_q <= 1'b0;
      if (early_set_w)    early_q <= 1'b1;
      else if (clr_early) early_q <= 1'b0;
      if (late_set_w)     late_q  <= 1'b1;
      else if (clr_late)  late_q  <= 1'b0;
    end
  end

  // R5
  lock_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |=> !unlocked_q);

  // R5
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked_q && !early_q && !late_q) |=> (!early_q && !late_q));

  // R6
  early_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_w && fs_edge_w && !at_wrap_w) |=> (early_q && cnt_q == '0));

  // R7
  late_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_w && at_wrap_w && !fs_edge_w) |=> (late_q && cnt_q == '0));

  // R9
  early_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(slave_mode && !ac97_mode) && !early_q) |=> !early_q);

  // R9
  late_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(slave_mode && !ac97_mode) && !late_q) |=> !late_q);

  // R10
  early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (early_q && !clr_early) |=> early_q);

  // R10
  late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (late_q && !clr_late) |=> late_q);

endmodule

// File: rtl/aud_irq_gen.sv
module aud_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic early_q,
  input  logic late_q,
  input  logic irq_en_early,
  input  logic irq_en_late,
  output logic irq_q
);

  logic req_w;

  always_comb req_w = (early_q & irq_en_early) | (late_q & irq_en_late);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= req_w;
  end

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((early_q && irq_en_early) || (late_q && irq_en_late)) |=> irq_q);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(early_q && irq_en_early) && !(late_q && irq_en_late)) |=> !irq_q);

endmodule

// File: rtl/aud_stat_unit.sv
module aud_stat_unit
  import aud_stat_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned FRAME_LEN  = 8,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_mode,
  input  logic             slave_mode,
  input  logic             ac97_mode,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             fsync,
  input  logic             clr_early,
  input  logic             clr_late,
  input  logic             irq_en_early,
  input  logic             irq_en_late,
  output logic [31:0]      status_word,
  output logic             irq
);

  logic [2:0] level_q;
  logic       early_q;
  logic       late_q;
  logic       unlocked_q;

  aud_fifo_level #(.FIFO_DEPTH(FIFO_DEPTH)) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_mode    (tx_mode),
    .fifo_count (fifo_count),
    .level_q    (level_q)
  );

  aud_fsync_mon #(.FRAME_LEN(FRAME_LEN)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_mode (slave_mode),
    .ac97_mode  (ac97_mode),
    .fsync      (fsync),
    .clr_early  (clr_early),
    .clr_late   (clr_late),
    .early_q    (early_q),
    .late_q     (late_q),
    .unlocked_q (unlocked_q)
  );

  aud_irq_gen u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .early_q      (early_q),
    .late_q       (late_q),
    .irq_en_early (irq_en_early),
    .irq_en_late  (irq_en_late),
    .irq_q        (irq)
  );

  always_comb begin
    status_word = '0;
    status_word[SW_LVL_LO +: 3] = level_q;
    status_word[SW_LATE]        = late_q;
    status_word[SW_EARLY]       = early_q;
    status_word[SW_UNLOCKED]    = unlocked_q;
  end

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[31:19] == '0) && (status_word[15:7] == '0) &&
    !status_word[4] && (status_word[2:0] == '0));

endmodule

// File: tb/aud_stat_unit_tb.sv
`timescale 1ns/1ps
module aud_stat_unit_tb_top;

  localparam int unsigned DEPTH = 8;
  localparam int unsigned FLEN  = 8;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_mode = 1'b0;
  logic          slave_mode = 1'b0;
  logic          ac97_mode = 1'b0;
  logic [CW-1:0] fifo_count = '0;
  logic          fsync = 1'b0;
  logic          clr_early = 1'b0;
  logic          clr_late = 1'b0;
  logic          irq_en_early = 1'b0;
  logic          irq_en_late = 1'b0;
  logic [31:0]   status_word;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  aud_stat_unit #(.FIFO_DEPTH(DEPTH), .FRAME_LEN(FLEN)) dut_i (
    .clk, .rst_n, .tx_mode, .slave_mode, .ac97_mode, .fifo_count, .fsync,
    .clr_early, .clr_late, .irq_en_early, .irq_en_late, .status_word, .irq
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int ref_level(input int c, input bit tx);
    real f;
    f = real'(c) / real'(DEPTH);
    if (c == 0) return 0;
    if (c == int'(DEPTH)) return 5;
    if (tx) return (f <= 0.25) ? 1 : (f <= 0.5) ? 2 : (f <= 0.75) ? 3 : 4;
    return (f < 0.25) ? 1 : (f < 0.5) ? 2 : (f < 0.75) ? 3 : 4;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a falling edge: fsync high for one cycle, returns at the next falling edge
  task automatic pulse(input bit with_clr_early);
    fsync = 1'b1;
    clr_early = with_clr_early;
    @(negedge clk);
    fsync = 1'b0;
    clr_early = 1'b0;
  endtask

  task automatic do_reset(input bit slave, input bit ac97);
    rst_n = 1'b0;
    slave_mode = slave;
    ac97_mode = ac97;
    fsync = 1'b0;
    clr_early = 1'b0;
    clr_late = 1'b0;
    irq_en_early = 1'b0;
    irq_en_late = 1'b0;
    fifo_count = '0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b0);
    check("R1 status after reset", status_word, 32'h0000_0008);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_levels(input bit tx);
    do_reset(1'b1, 1'b0);
    tx_mode = tx;
    for (int c = DEPTH; c >= 0; c--) begin
      fifo_count = CW'(c);
      @(negedge clk);
      check(tx ? "R2 tx level" : "R3 rx level", {29'b0, status_word[18:16]},
            32'(ref_level(c, tx)));
      // R12
      check("R12 no reserved code", {31'b0, status_word[18:16] > 3'd5}, 32'h0);
      // R4
      check("R4 reserved bits", status_word & 32'hFFF8_FF97, 32'h0);
    end
  endtask

  task automatic t_lock_and_ontime();
    do_reset(1'b1, 1'b0);
    idle(2 * FLEN);
    check("R5 no late flag before lock", {31'b0, status_word[6]}, 32'h0);
    check("R5 unlocked before first edge", {31'b0, status_word[3]}, 32'h1);
    pulse(1'b0);
    check("R5 locked after edge", {31'b0, status_word[3]}, 32'h0);
    for (int k = 0; k < 3; k++) begin
      idle(FLEN - 1);
      pulse(1'b0);
      check("R8 on-time early flag", {31'b0, status_word[5]}, 32'h0);
      check("R8 on-time late flag", {31'b0, status_word[6]}, 32'h0);
    end
  endtask

  task automatic t_early();
    do_reset(1'b1, 1'b0);
    irq_en_early = 1'b1;
    pulse(1'b0);
    idle(FLEN - 3);
    pulse(1'b0);
    check("R6 early flag set", {31'b0, status_word[5]}, 32'h1);
    check("R11 irq not before one cycle", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R11 irq follows early flag", {31'b0, irq}, 32'h1);
    // counter restarted at the early edge: next on-time edge FLEN clocks later
    clr_early = 1'b1;
    @(negedge clk);
    clr_early = 1'b0;
    idle(FLEN - 3);
    pulse(1'b0);
    check("R6 resync on-time early", {31'b0, status_word[5]}, 32'h0);
    check("R6 resync on-time late", {31'b0, status_word[6]}, 32'h0);
  endtask

  task automatic t_late();
    do_reset(1'b1, 1'b0);
    irq_en_late = 1'b0;
    pulse(1'b0);
    idle(FLEN - 1);
    check("R7 late flag not yet", {31'b0, status_word[6]}, 32'h0);
    @(negedge clk);
    check("R7 late flag set", {31'b0, status_word[6]}, 32'h1);
    @(negedge clk);
    check("R11 irq masked", {31'b0, irq}, 32'h0);
    irq_en_late = 1'b1;
    idle(2);
    check("R11 irq when enabled", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_gating(input bit slave, input bit ac97);
    do_reset(slave, ac97);
    pulse(1'b0);
    idle(1);
    pulse(1'b0);
    check("R9 no early flag when gated", {31'b0, status_word[5]}, 32'h0);
    idle(FLEN + 2);
    check("R9 no late flag when gated", {31'b0, status_word[6]}, 32'h0);
    check("R5 lock in any mode", {31'b0, status_word[3]}, 32'h0);
  endtask

  task automatic t_sticky();
    do_reset(1'b1, 1'b0);
    pulse(1'b0);
    idle(1);
    pulse(1'b0);
    idle(2);
    check("R10 early flag held", {31'b0, status_word[5]}, 32'h1);
    clr_early = 1'b1;
    @(negedge clk);
    clr_early = 1'b0;
    check("R10 early flag cleared", {31'b0, status_word[5]}, 32'h0);
    pulse(1'b1);
    check("R10 set wins over clear", {31'b0, status_word[5]}, 32'h1);
    clr_late = 1'b1;
    @(negedge clk);
    clr_late = 1'b0;
    check("R10 other clear no effect", {31'b0, status_word[5]}, 32'h1);
  endtask

  initial begin
    t_reset();
    t_levels(1'b1);
    t_levels(1'b0);
    t_lock_and_ontime();
    t_early();
    t_late();
    t_gating(1'b0, 1'b0);
    t_gating(1'b1, 1'b1);
    t_sticky();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule